// File: doc/BRIEF.md
# Power domain gating sequencer

This block switches one gateable logic domain off and back on under software control. Software programs it through a small word-addressed register port: a control word with one request bit for each direction, a gating-enable word, and two timing words that set how long each step of the power-down and power-up sequences lasts. The sequencer drives four outputs: the isolation clamp, the power-switch enable, a domain reset and a clock request.

To switch the domain off, isolation and reset are raised first. After the isolation delay and then the isolation-to-switch delay, the switch opens. To switch it back on, the switch closes and the clock request rises. After the switch delay and then the switch-to-isolation delay, isolation drops. Reset and the clock request fall one cycle after that. Each request bit reads back as 1 while its sequence runs and clears itself when the sequence ends. A step programmed to 0 cycles lasts one cycle.

Top module: `pgs_top`

## Requirements
- R1: After reset the domain is powered (`dom_pwr_on`=1), `dom_iso`, `dom_rst` and `dom_clk_req` are 0, and every register reads 0.
- R2: Word offsets: 0 is control, 1 is gating-enable (bit 0), 2 is power-down timing and 3 is power-up timing. Each timing word holds its first-step delay in bits 5:0 and its second-step delay in bits 13:8; every other bit and every other offset reads 0.
- R3: While powered with gating enabled, writing 1 to control bit 0 raises `dom_iso` and `dom_rst` on the edge that accepts the write. `dom_pwr_on` falls exactly D1+D2 cycles later, where D1 and D2 are the power-down fields and a field of 0 counts as 1.
- R4: A power-down request written while gating-enable bit 0 is 0 changes no output, and control reads 0.
- R5: While off, writing 1 to control bit 1 raises `dom_pwr_on` and `dom_clk_req` on the accepting edge. `dom_iso` falls exactly U1+U2 cycles later (power-up fields, 0 counts as 1), and `dom_rst` and `dom_clk_req` fall one cycle after `dom_iso`.
- R6: Control bit 0 (power-down) or bit 1 (power-up) reads 1 from the accepting edge until the edge that ends its sequence, then reads 0. The power-down sequence ends when the switch opens; the power-up sequence ends when reset is released.
- R7: When both request bits are written as 1 together, the power-up request wins: while powered nothing happens, and while off the domain powers up.
- R8: A control write during a running sequence has no effect. So does a power-up request while powered, and a power-down request while off.
- R9: `dom_rst` is 1 whenever `dom_iso` is 1, and `dom_iso` is 1 whenever `dom_pwr_on` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral-bus clock; all delays count its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational from `bus_addr` |
| dom_iso | output | 1 | Isolation clamp enable for the domain outputs |
| dom_pwr_on | output | 1 | Power switch enable, 1 = domain supplied |
| dom_rst | output | 1 | Domain reset, active high |
| dom_clk_req | output | 1 | Requests the domain clocks during power-up |

## Verification
The assertions assume that `rst_n` is held low long enough to clear every register. They also assume that the outputs move only under the sequencer, so the only way to change them is a control write. The stimulus starts each sequence only from the stable state its requirement names. It drives writes as single-cycle strobes between clock edges and changes timing words only while no sequence is running. As a result, every output edge the bench expects follows from a write whose accepting edge is known.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

   // sequencer states
   typedef enum logic [2:0] {
      ST_ON     = 3'd0,
      ST_PD_ISO = 3'd1,
      ST_PD_SW  = 3'd2,
      ST_OFF    = 3'd3,
      ST_PU_SW  = 3'd4,
      ST_PU_ISO = 3'd5,
      ST_PU_RST = 3'd6
   } pgs_state_e;

   // register word offsets
   localparam int unsigned OFS_CTRL  = 0;
   localparam int unsigned OFS_GATE  = 1;
   localparam int unsigned OFS_PDN_T = 2;
   localparam int unsigned OFS_PUP_T = 3;

   // control word bit positions
   localparam int unsigned REQ_PDN_BIT = 0;
   localparam int unsigned REQ_PUP_BIT = 1;

   // index of each step delay in the delay vector: register*2 + field
   localparam int unsigned DLY_ISO    = 0;
   localparam int unsigned DLY_ISO2SW = 1;
   localparam int unsigned DLY_SW     = 2;
   localparam int unsigned DLY_SW2ISO = 3;
   localparam int unsigned DLY_NUM    = 4;

endpackage

// File: rtl/pgs_regs.sv
module pgs_regs
   import pgs_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DLY_W  = 6,
   parameter int unsigned HI_LSB = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wen,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [1:0]        busy_i,
   output logic              gate_en_o,
   output logic              ctrl_wr_o,
   output logic [1:0]        ctrl_req_o,
   output logic [DLY_W-1:0]  dly_o [DLY_NUM]
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(OFS_GATE);
   localparam logic [ADDR_W-1:0] A_PDN  = ADDR_W'(OFS_PDN_T);
   localparam logic [ADDR_W-1:0] A_PUP  = ADDR_W'(OFS_PUP_T);
   localparam int unsigned       N_TREG = 2;
   localparam int unsigned       N_FLD  = 2;

   logic gate_q;
   logic unused_wdata;

   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
      end else if (bus_wen && (bus_addr == A_GATE)) begin
         gate_q <= bus_wdata[0];
      end
   end

   assign gate_en_o  = gate_q;
   assign ctrl_wr_o  = bus_wen && (bus_addr == A_CTRL);
   assign ctrl_req_o = {bus_wdata[REQ_PUP_BIT], bus_wdata[REQ_PDN_BIT]};

   // timing registers: two words, two fields each
   for (genvar r = 0; r < N_TREG; r++) begin : g_treg
      localparam logic [ADDR_W-1:0] A_R = (r == 0) ? A_PDN : A_PUP;
      logic              wr_hit;
      logic [DATA_W-1:0] word;

      assign wr_hit = bus_wen && (bus_addr == A_R);

      for (genvar f = 0; f < N_FLD; f++) begin : g_fld
         localparam int unsigned LSB = f * HI_LSB;
         logic [DLY_W-1:0] fld_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fld_q <= '0;
            end else if (wr_hit) begin
               fld_q <= bus_wdata[LSB +: DLY_W];
            end
         end

         assign dly_o[r*N_FLD + f] = fld_q;
      end

      always_comb begin
         word = '0;
         word[0 +: DLY_W]      = g_fld[0].fld_q;
         word[HI_LSB +: DLY_W] = g_fld[1].fld_q;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CTRL) begin
         bus_rdata[REQ_PDN_BIT] = busy_i[0];
         bus_rdata[REQ_PUP_BIT] = busy_i[1];
      end else if (bus_addr == A_GATE) begin
         bus_rdata[0] = gate_q;
      end else if (bus_addr == A_PDN) begin
         bus_rdata = g_treg[0].word;
      end else if (bus_addr == A_PUP) begin
         bus_rdata = g_treg[1].word;
      end
   end

endmodule

// File: rtl/pgs_delay.sv
module pgs_delay #(
   parameter int unsigned DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DLY_W-1:0] len_i,
   output logic             done_o
);

   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   logic [DLY_W-1:0] cnt_q;
   logic [DLY_W-1:0] start_val;

   // a zero field still gives a one-cycle step
   assign start_val = (len_i == '0) ? ONE : len_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= start_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign done_o = (cnt_q == ONE);

endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
   import pgs_pkg::*;
#(
   parameter int unsigned DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr_i,
   input  logic [1:0]       ctrl_req_i,
   input  logic             gate_en_i,
   input  logic [DLY_W-1:0] dly_i [DLY_NUM],
   input  logic             dly_done_i,
   output logic             dly_load_o,
   output logic [DLY_W-1:0] dly_len_o,
   output logic [1:0]       busy_o,
   output logic             iso_o,
   output logic             pwr_on_o,
   output logic             rst_o,
   output logic             clk_req_o
);

   pgs_state_e st_q, st_d;
   logic       req_pdn, req_pup;
   logic       iso_q, pwr_q, rst_q, clk_q;
   logic [1:0] busy_q;
   logic       iso_d;

   assign req_pdn = ctrl_wr_i && ctrl_req_i[0] && !ctrl_req_i[1] && gate_en_i;
   assign req_pup = ctrl_wr_i && ctrl_req_i[1];

   always_comb begin
      st_d       = st_q;
      dly_load_o = 1'b0;
      dly_len_o  = '0;
      unique case (st_q)
         ST_ON: begin
            if (req_pdn) begin
               st_d       = ST_PD_ISO;
               dly_load_o = 1'b1;
               dly_len_o  = dly_i[DLY_ISO];
            end
         end
         ST_PD_ISO: begin
            if (dly_done_i) begin
               st_d       = ST_PD_SW;
               dly_load_o = 1'b1;
               dly_len_o  = dly_i[DLY_ISO2SW];
            end
         end
         ST_PD_SW: begin
            if (dly_done_i) st_d = ST_OFF;
         end
         ST_OFF: begin
            if (req_pup) begin
               st_d       = ST_PU_SW;
               dly_load_o = 1'b1;
               dly_len_o  = dly_i[DLY_SW];
            end
         end
         ST_PU_SW: begin
            if (dly_done_i) begin
               st_d       = ST_PU_ISO;
               dly_load_o = 1'b1;
               dly_len_o  = dly_i[DLY_SW2ISO];
            end
         end
         ST_PU_ISO: begin
            if (dly_done_i) st_d = ST_PU_RST;
         end
         ST_PU_RST: st_d = ST_ON;
         default:   st_d = ST_ON;
      endcase
   end

   assign iso_d = (st_d == ST_PD_ISO) || (st_d == ST_PD_SW) || (st_d == ST_OFF) ||
                  (st_d == ST_PU_SW)  || (st_d == ST_PU_ISO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_ON;
         iso_q  <= 1'b0;
         pwr_q  <= 1'b1;
         rst_q  <= 1'b0;
         clk_q  <= 1'b0;
         busy_q <= 2'b00;
      end else begin
         st_q      <= st_d;
         iso_q     <= iso_d;
         pwr_q     <= (st_d != ST_OFF);
         rst_q     <= iso_d || (st_d == ST_PU_RST);
         clk_q     <= (st_d == ST_PU_SW) || (st_d == ST_PU_ISO) || (st_d == ST_PU_RST);
         busy_q[0] <= (st_d == ST_PD_ISO) || (st_d == ST_PD_SW);
         busy_q[1] <= (st_d == ST_PU_SW) || (st_d == ST_PU_ISO) || (st_d == ST_PU_RST);
      end
   end

   assign busy_o    = busy_q;
   assign iso_o     = iso_q;
   assign pwr_on_o  = pwr_q;
   assign rst_o     = rst_q;
   assign clk_req_o = clk_q;

endmodule

// File: rtl/pgs_top.sv
module pgs_top
   import pgs_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DLY_W  = 6,
   parameter int unsigned HI_LSB = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wen,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              dom_iso,
   output logic              dom_pwr_on,
   output logic              dom_rst,
   output logic              dom_clk_req
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("pgs_top: ADDR_W must reach four words");
   end
   if ((DLY_W < 1) || (DLY_W > HI_LSB)) begin : g_bad_dly
      $error("pgs_top: DLY_W must be 1..HI_LSB");
   end
   if (DATA_W < HI_LSB + DLY_W) begin : g_bad_data
      $error("pgs_top: DATA_W too narrow for both timing fields");
   end

   logic             gate_en_w;
   logic             ctrl_wr_w;
   logic [1:0]       ctrl_req_w;
   logic [1:0]       busy_w;
   logic [DLY_W-1:0] dly_w [DLY_NUM];
   logic             dly_load_w;
   logic [DLY_W-1:0] dly_len_w;
   logic             dly_done_w;

   pgs_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DLY_W  (DLY_W),
      .HI_LSB (HI_LSB)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wen    (bus_wen),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .busy_i     (busy_w),
      .gate_en_o  (gate_en_w),
      .ctrl_wr_o  (ctrl_wr_w),
      .ctrl_req_o (ctrl_req_w),
      .dly_o      (dly_w)
   );

   pgs_delay #(
      .DLY_W (DLY_W)
   ) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (dly_load_w),
      .len_i  (dly_len_w),
      .done_o (dly_done_w)
   );

   pgs_fsm #(
      .DLY_W (DLY_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr_i  (ctrl_wr_w),
      .ctrl_req_i (ctrl_req_w),
      .gate_en_i  (gate_en_w),
      .dly_i      (dly_w),
      .dly_done_i (dly_done_w),
      .dly_load_o (dly_load_w),
      .dly_len_o  (dly_len_w),
      .busy_o     (busy_w),
      .iso_o      (dom_iso),
      .pwr_on_o   (dom_pwr_on),
      .rst_o      (dom_rst),
      .clk_req_o  (dom_clk_req)
   );

endmodule

// File: rtl/pgs_chk.sv
module pgs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       iso,
   input logic       pwr_on,
   input logic       rst,
   input logic       clk_req,
   input logic [1:0] busy
);

   // R9
   rst_covers_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iso |-> rst);

   // R9
   off_needs_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |-> iso);

   // R3
   iso_before_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_on) |-> $past(iso));

   // R5
   rst_after_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso) |=> $fell(rst));

   // R5
   clk_with_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_on) |-> clk_req);

   // R5
   clk_drops_with_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_req) |-> $fell(rst));

   // R6
   one_sequence_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(busy));

endmodule

bind pgs_top pgs_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .iso     (dom_iso),
   .pwr_on  (dom_pwr_on),
   .rst     (dom_rst),
   .clk_req (dom_clk_req),
   .busy    (busy_w)
);

// File: tb/test_pgs_top.sv
module test_pgs_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wen = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        dom_iso, dom_pwr_on, dom_rst, dom_clk_req;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   pgs_top i_pgs_top (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wen     (bus_wen),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .dom_iso     (dom_iso),
      .dom_pwr_on  (dom_pwr_on),
      .dom_rst     (dom_rst),
      .dom_clk_req (dom_clk_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int stp(input int f);
      return (f == 0) ? 1 : f;
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 pwr_on", dom_pwr_on, 1);
      chk("R1 iso", dom_iso, 0);
      chk("R1 rst", dom_rst, 0);
      chk("R1 clk_req", dom_clk_req, 0);
      for (int a = 0; a < 4; a++) begin
         rd(a[3:0], v);
         chk("R1 reg zero", v, 0);
      end
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, v); chk("R2 pdn timing mask", v, 32'h3F3F);
      wr(4'd3, 32'h0000_2A15); rd(4'd3, v); chk("R2 pup timing fields", v, 32'h2A15);
      wr(4'd1, 32'hFFFF_FFFE); rd(4'd1, v); chk("R2 gate bit0 only", v, 0);
      wr(4'd1, 32'h0000_0003); rd(4'd1, v); chk("R2 gate readback", v, 1);
      rd(4'd7, v); chk("R2 unmapped offset", v, 0);
      chk("R8 timing writes leave outputs", {dom_iso, dom_pwr_on}, 2'b01);
      wr(4'd1, 32'h0);
   endtask

   task automatic t_pdn_blocked();
      logic [31:0] v;
      wr(4'd1, 32'h0);
      wr(4'd0, 32'h1);
      cyc(4);
      chk("R4 iso stays low", dom_iso, 0);
      chk("R4 power stays on", dom_pwr_on, 1);
      rd(4'd0, v); chk("R4 ctrl reads 0", v, 0);
   endtask

   task automatic t_pdn(input int a, input int b);
      logic [31:0] v;
      int n;
      n = stp(a) + stp(b);
      wr(4'd2, (b << 8) | a);
      wr(4'd1, 32'h1);
      wr(4'd0, 32'h1);
      chk("R3 iso at accept", dom_iso, 1);
      chk("R3 rst at accept", dom_rst, 1);
      chk("R3 still powered", dom_pwr_on, 1);
      rd(4'd0, v); chk("R6 pdn busy", v, 1);
      cyc(n - 1);
      chk("R3 switch closed before end", dom_pwr_on, 1);
      cyc(1);
      chk("R3 switch open at end", dom_pwr_on, 0);
      chk("R9 iso while off", dom_iso, 1);
      rd(4'd0, v); chk("R6 pdn bit cleared", v, 0);
   endtask

   task automatic t_pdn_busy_write(input int a, input int b);
      logic [31:0] v;
      int n;
      n = stp(a) + stp(b);
      wr(4'd2, (b << 8) | a);
      wr(4'd1, 32'h1);
      wr(4'd0, 32'h1);
      wr(4'd0, 32'h2);
      chk("R8 clk_req untouched mid pdn", dom_clk_req, 0);
      rd(4'd0, v); chk("R8 busy unchanged", v, 1);
      cyc(n - 3);
      chk("R8 switch closed before end", dom_pwr_on, 1);
      cyc(1);
      chk("R8 switch opens on time", dom_pwr_on, 0);
   endtask

   task automatic t_off_ignore();
      logic [31:0] v;
      wr(4'd0, 32'h1);
      cyc(4);
      chk("R8 stays off", dom_pwr_on, 0);
      chk("R8 iso held", dom_iso, 1);
      rd(4'd0, v); chk("R8 ctrl reads 0 when off", v, 0);
   endtask

   task automatic t_pup(input int a, input int b, input logic [31:0] req);
      logic [31:0] v;
      int m;
      m = stp(a) + stp(b);
      wr(4'd3, (b << 8) | a);
      wr(4'd0, req);
      chk("R5 switch closes at accept", dom_pwr_on, 1);
      chk("R5 clk_req at accept", dom_clk_req, 1);
      chk("R9 iso held", dom_iso, 1);
      rd(4'd0, v); chk("R6 pup busy", v, 2);
      cyc(m - 1);
      chk("R5 iso before end", dom_iso, 1);
      cyc(1);
      chk("R5 iso released", dom_iso, 0);
      chk("R5 rst still held", dom_rst, 1);
      chk("R5 clk_req still held", dom_clk_req, 1);
      rd(4'd0, v); chk("R6 pup busy at iso drop", v, 2);
      cyc(1);
      chk("R5 rst released", dom_rst, 0);
      chk("R5 clk_req dropped", dom_clk_req, 0);
      rd(4'd0, v); chk("R6 pup bit cleared", v, 0);
   endtask

   task automatic t_both_on();
      logic [31:0] v;
      wr(4'd1, 32'h1);
      wr(4'd0, 32'h3);
      cyc(4);
      chk("R7 no power-down when both set", dom_iso, 0);
      chk("R7 power stays on", dom_pwr_on, 1);
      rd(4'd0, v); chk("R7 ctrl idle", v, 0);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_regs();
      t_pdn_blocked();
      t_pdn(3, 5);
      t_off_ignore();
      t_pup(4, 2, 32'h2);
      t_both_on();
      t_pdn(0, 0);
      t_pup(0, 7, 32'h3);   // R7 both bits while off powers up
      t_pdn_busy_write(63, 63);
      t_pup(63, 1, 32'h2);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule